// File: doc/BRIEF.md
# Cartridge Bank-Switching Mapper

This block is the memory-mapping controller of a game-console cartridge. It sits between the 8-bit CPU bus, the picture-processor (PPU) bus and two 128 KiB ROMs: one holds the program and one holds the pattern data. When the CPU writes anywhere in the upper half of its address space, the block loads one entry of a small register file. It never drives data back onto the CPU bus.

From the register file, the block forms the program-ROM address for the four 8 KiB CPU windows. Three of these windows are switchable and the top one is fixed. It also forms the pattern-ROM address for the eight 1 KiB PPU windows. Each of the four nametables has its own page-select bit, which drives the video-RAM page line. Address translation is combinational from the current register contents, so a new bank is visible from the cycle after the write edge.

The register decode is deliberately partial. Address bit 4 picks the register family, and a few low or high bits pick the entry. All other bits are ignored, so every register appears at many aliased addresses.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write strobe with cpu_addr[15] = 0 changes no register. Writes are accepted only in the $8000–$FFFF region.
- R2: A write with cpu_addr[4] = 0 and cpu_addr[14:13] = k (k in 0..2) loads program slot k with cpu_wdata[3:0]. Higher data bits are dropped. While cpu_addr[14:13] = k, prg_rom_addr = {slot k, cpu_addr[12:0]}.
- R3: A write that decodes to program slot 3 (cpu_addr[14:13] = 3, cpu_addr[4] = 0) changes nothing. The $E000–$FFFF window always reads bank 15, so prg_rom_addr = {4'hF, cpu_addr[12:0]}.
- R4: A write with cpu_addr[4] = 1 and cpu_addr[3] = 0 loads pattern slot cpu_addr[2:0] with cpu_wdata[6:0]. chr_rom_addr = {pattern slot ppu_addr[12:10], ppu_addr[9:0]}.
- R5: A write with cpu_addr[4] = 1 and cpu_addr[3] = 1 stores cpu_wdata[0] as the page bit of nametable cpu_addr[1:0]. The other data bits are discarded.
- R6: All other address bits are ignored by the decode. A write to $F018 sets nametable 0, a write to $C003 loads program slot 2, and a write to $A010 loads pattern slot 0.
- R7: vram_page equals the page bit of nametable ppu_addr[11:10]. vram_cs is 1 exactly when ppu_addr lies in $2000–$3EFF.
- R8: A synchronous reset sets every program, pattern and nametable register to 0. Afterwards the first three CPU windows and all pattern windows show bank 0, while $E000–$FFFF still shows bank 15.
- R9: One write event updates exactly one register, and the new value appears in the translated addresses in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Qualified CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | PPU address bus |
| prg_rom_addr | output | 17 | Banked program-ROM address |
| chr_rom_addr | output | 17 | Banked pattern-ROM address |
| vram_page | output | 1 | Video-RAM page select for the current nametable |
| vram_cs | output | 1 | Video-RAM chip enable, high across $2000–$3EFF |

## Verification
The assertions assume the following about the inputs:
- cpu_wr is a strobe already qualified by the CPU, high for exactly one clock per write.
- cpu_addr and cpu_wdata are settled at that edge.
- Reset is synchronous and is applied at the first edge.

The stimulus drives every input on the falling clock edge and holds the strobe for a single rising edge, so each write lands at one known edge. Translated addresses are read while the strobe is low, so a lookup never overlaps a write.

// File: rtl/cart_mapper_pkg.sv
package cart_mapper_pkg;
  // Target family chosen by the register decode
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PRG  = 2'd1,
    TGT_CHR  = 2'd2,
    TGT_NT   = 2'd3
  } wr_target_t;

  // Decode bit positions the behaviour depends on
  localparam int FAMILY_BIT  = 4;
  localparam int SUBFAM_BIT  = 3;
  localparam int PRG_SEL_LSB = 13;
  localparam int PRG_WIN_LSB = 13;
  localparam int CHR_WIN_LSB = 10;
  localparam int NT_IDX_LSB  = 10;
endpackage

// File: rtl/mapper_wr_decode.sv
module mapper_wr_decode
  import cart_mapper_pkg::*;
#(
  parameter int CPU_AW    = 16,
  parameter int PRG_SLOTS = 3,
  parameter int CHR_SLOTS = 8,
  parameter int NT_COUNT  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic                 cpu_wr,
  output logic [PRG_SLOTS-1:0] prg_we,
  output logic [CHR_SLOTS-1:0] chr_we,
  output logic [NT_COUNT-1:0]  nt_we
);
  localparam int PRG_SEL_W = $clog2(PRG_SLOTS + 1);
  localparam int CHR_SEL_W = $clog2(CHR_SLOTS);
  localparam int NT_SEL_W  = $clog2(NT_COUNT);

  wr_target_t              target;
  logic [PRG_SEL_W-1:0]    prg_sel;
  logic [CHR_SEL_W-1:0]    chr_sel;
  logic [NT_SEL_W-1:0]     nt_sel;

  assign prg_sel = cpu_addr[PRG_SEL_LSB +: PRG_SEL_W];
  assign chr_sel = cpu_addr[CHR_SEL_W-1:0];
  assign nt_sel  = cpu_addr[NT_SEL_W-1:0];

  always_comb begin
    target = TGT_NONE;
    if (cpu_wr && cpu_addr[CPU_AW-1]) begin
      if (!cpu_addr[FAMILY_BIT])      target = TGT_PRG;
      else if (!cpu_addr[SUBFAM_BIT]) target = TGT_CHR;
      else                            target = TGT_NT;
    end
  end

  for (genvar i = 0; i < PRG_SLOTS; i++) begin : g_prg
    assign prg_we[i] = (target == TGT_PRG) && (prg_sel == PRG_SEL_W'(i));
  end
  for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_chr
    assign chr_we[i] = (target == TGT_CHR) && (chr_sel == CHR_SEL_W'(i));
  end
  for (genvar i = 0; i < NT_COUNT; i++) begin : g_nt
    assign nt_we[i] = (target == TGT_NT) && (nt_sel == NT_SEL_W'(i));
  end

  // R1
  low_half_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_addr[CPU_AW-1] |-> ({prg_we, chr_we, nt_we} == '0));
  // R9
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prg_we, chr_we, nt_we}));
  // R3
  fixed_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_addr[FAMILY_BIT] && (&prg_sel)) |-> (prg_we == '0));
endmodule

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs #(
  parameter int DATA_W     = 8,
  parameter int PRG_SLOTS  = 3,
  parameter int CHR_SLOTS  = 8,
  parameter int NT_COUNT   = 4,
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 7
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [DATA_W-1:0]                     wdata,
  input  logic [PRG_SLOTS-1:0]                  prg_we,
  input  logic [CHR_SLOTS-1:0]                  chr_we,
  input  logic [NT_COUNT-1:0]                   nt_we,
  output logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]  prg_bank,
  output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank,
  output logic [NT_COUNT-1:0]                   nt_page
);
  for (genvar i = 0; i < PRG_SLOTS; i++) begin : g_prg
    always_ff @(posedge clk) begin
      if (rst)            prg_bank[i] <= '0;
      else if (prg_we[i]) prg_bank[i] <= wdata[PRG_BANK_W-1:0];
    end
    // R2
    prg_load_chk: assert property (@(posedge clk) disable iff (rst)
      prg_we[i] |=> (prg_bank[i] == $past(wdata[PRG_BANK_W-1:0])));
  end

  for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_chr
    always_ff @(posedge clk) begin
      if (rst)            chr_bank[i] <= '0;
      else if (chr_we[i]) chr_bank[i] <= wdata[CHR_BANK_W-1:0];
    end
    // R4
    chr_load_chk: assert property (@(posedge clk) disable iff (rst)
      chr_we[i] |=> (chr_bank[i] == $past(wdata[CHR_BANK_W-1:0])));
  end

  for (genvar i = 0; i < NT_COUNT; i++) begin : g_nt
    always_ff @(posedge clk) begin
      if (rst)           nt_page[i] <= 1'b0;
      else if (nt_we[i]) nt_page[i] <= wdata[0];
    end
  end

  // R5
  nt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nt_we == '0) |=> $stable(nt_page));
  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (prg_bank == '0 && chr_bank == '0 && nt_page == '0));
endmodule

// File: rtl/mapper_addr_xlate.sv
module mapper_addr_xlate
  import cart_mapper_pkg::*;
#(
  parameter int CPU_AW     = 16,
  parameter int PPU_AW     = 14,
  parameter int PRG_SLOTS  = 3,
  parameter int CHR_SLOTS  = 8,
  parameter int NT_COUNT   = 4,
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 7
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [CPU_AW-1:0]                     cpu_addr,
  input  logic [PPU_AW-1:0]                     ppu_addr,
  input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]  prg_bank,
  input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]  chr_bank,
  input  logic [NT_COUNT-1:0]                   nt_page,
  output logic [PRG_BANK_W+PRG_WIN_LSB-1:0]     prg_rom_addr,
  output logic [CHR_BANK_W+CHR_WIN_LSB-1:0]     chr_rom_addr,
  output logic                                  vram_page,
  output logic                                  vram_cs
);
  localparam int WINDOWS   = PRG_SLOTS + 1;
  localparam int WIN_SEL_W = $clog2(WINDOWS);
  localparam int CHR_SEL_W = $clog2(CHR_SLOTS);
  localparam int NT_SEL_W  = $clog2(NT_COUNT);

  // Top window pinned to the last bank
  logic [WINDOWS-1:0][PRG_BANK_W-1:0] win_bank;
  logic [WIN_SEL_W-1:0]               win_sel;
  logic [CHR_SEL_W-1:0]               chr_sel;
  logic [NT_SEL_W-1:0]                nt_sel;

  assign win_bank = {{PRG_BANK_W{1'b1}}, prg_bank};
  assign win_sel  = cpu_addr[PRG_WIN_LSB +: WIN_SEL_W];
  assign chr_sel  = ppu_addr[CHR_WIN_LSB +: CHR_SEL_W];
  assign nt_sel   = ppu_addr[NT_IDX_LSB +: NT_SEL_W];

  assign prg_rom_addr = {win_bank[win_sel], cpu_addr[PRG_WIN_LSB-1:0]};
  assign chr_rom_addr = {chr_bank[chr_sel], ppu_addr[CHR_WIN_LSB-1:0]};
  assign vram_page    = nt_page[nt_sel];
  // $2000..$3EFF: bit 13 set and not the $3Fxx page
  assign vram_cs      = ppu_addr[PPU_AW-1] && (ppu_addr[PPU_AW-2:8] != '1);

  // R3
  top_window_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (&win_sel) |-> (&prg_rom_addr[PRG_BANK_W+PRG_WIN_LSB-1:PRG_WIN_LSB]));
  // R7
  vram_region_chk: assert property (@(posedge clk) disable iff (rst)
    vram_cs |-> ppu_addr[PPU_AW-1]);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int CPU_AW     = 16,
  parameter int PPU_AW     = 14,
  parameter int DATA_W     = 8,
  parameter int PRG_SLOTS  = 3,
  parameter int CHR_SLOTS  = 8,
  parameter int NT_COUNT   = 4,
  parameter int PRG_BANK_W = 4,
  parameter int CHR_BANK_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic [DATA_W-1:0]        cpu_wdata,
  input  logic                     cpu_wr,
  input  logic [PPU_AW-1:0]        ppu_addr,
  output logic [PRG_BANK_W+12:0]   prg_rom_addr,
  output logic [CHR_BANK_W+9:0]    chr_rom_addr,
  output logic                     vram_page,
  output logic                     vram_cs
);
  logic [PRG_SLOTS-1:0]                 prg_we;
  logic [CHR_SLOTS-1:0]                 chr_we;
  logic [NT_COUNT-1:0]                  nt_we;
  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_bank;
  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_bank;
  logic [NT_COUNT-1:0]                  nt_page;

  mapper_wr_decode #(
    .CPU_AW(CPU_AW), .PRG_SLOTS(PRG_SLOTS),
    .CHR_SLOTS(CHR_SLOTS), .NT_COUNT(NT_COUNT)
  ) u_dec (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .prg_we(prg_we), .chr_we(chr_we), .nt_we(nt_we)
  );

  mapper_bank_regs #(
    .DATA_W(DATA_W), .PRG_SLOTS(PRG_SLOTS), .CHR_SLOTS(CHR_SLOTS),
    .NT_COUNT(NT_COUNT), .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wdata(cpu_wdata),
    .prg_we(prg_we), .chr_we(chr_we), .nt_we(nt_we),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .nt_page(nt_page)
  );

  mapper_addr_xlate #(
    .CPU_AW(CPU_AW), .PPU_AW(PPU_AW), .PRG_SLOTS(PRG_SLOTS),
    .CHR_SLOTS(CHR_SLOTS), .NT_COUNT(NT_COUNT),
    .PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W)
  ) u_xlate (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .nt_page(nt_page),
    .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
    .vram_page(vram_page), .vram_cs(vram_cs)
  );
endmodule

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [16:0] prg_rom_addr;
  logic [16:0] chr_rom_addr;
  logic        vram_page;
  logic        vram_cs;

  int n_checks = 0;
  int n_fail   = 0;

  logic [3:0] m_prg [3];
  logic [6:0] m_chr [8];
  logic       m_nt  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
    .chr_rom_addr(chr_rom_addr), .vram_page(vram_page), .vram_cs(vram_cs)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic look_prg(int win, string req);
    cpu_addr = 16'h8000 | 16'(win << 13) | 16'h0155;
    #1;
    chk(req, $sformatf("prg window %0d", win), 32'(prg_rom_addr),
        32'({(win == 3) ? 4'hF : m_prg[win], 13'h0155}));
  endtask

  task automatic look_chr(int slot, string req);
    ppu_addr = 14'(slot << 10) | 14'h02A5;
    #1;
    chk(req, $sformatf("chr window %0d", slot), 32'(chr_rom_addr),
        32'({m_chr[slot], 10'h2A5}));
  endtask

  task automatic look_nt(int idx, string req);
    ppu_addr = 14'h2000 | 14'(idx << 10) | 14'h0033;
    #1;
    chk(req, $sformatf("nt %0d page", idx), 32'(vram_page), 32'(m_nt[idx]));
  endtask

  task automatic look_all(string req);
    for (int w = 0; w < 4; w++) look_prg(w, req);
    for (int s = 0; s < 8; s++) look_chr(s, req);
    for (int i = 0; i < 4; i++) look_nt(i, req);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) m_prg[i] = '0;
    for (int i = 0; i < 8; i++) m_chr[i] = '0;
    for (int i = 0; i < 4; i++) m_nt[i]  = 1'b0;
  endtask

  task automatic t_reset();  // R8
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
    look_all("R8");
  endtask

  task automatic t_prg();  // R2, wrap to low 4 bits
    cpu_write(16'h8000, 8'h02); m_prg[0] = 4'h2;
    cpu_write(16'hA000, 8'hF3); m_prg[1] = 4'h3;
    cpu_write(16'hC000, 8'h0B); m_prg[2] = 4'hB;
    for (int w = 0; w < 3; w++) look_prg(w, "R2");
  endtask

  task automatic t_fixed();  // R3
    cpu_write(16'hE000, 8'h07);
    cpu_write(16'hE00F, 8'h00);
    for (int w = 0; w < 4; w++) look_prg(w, "R3");
  endtask

  task automatic t_chr();  // R4, wrap to low 7 bits
    for (int s = 0; s < 8; s++) begin
      cpu_write(16'h8010 | 16'(s), 8'(8'h80 | (s * 9 + 5)));
      m_chr[s] = 7'(s * 9 + 5);
    end
    for (int s = 0; s < 8; s++) look_chr(s, "R4");
  endtask

  task automatic t_nt();  // R5, only data bit 0 kept
    cpu_write(16'h8018, 8'hFF); m_nt[0] = 1'b1;
    cpu_write(16'h8019, 8'hFE); m_nt[1] = 1'b0;
    cpu_write(16'h801A, 8'h01); m_nt[2] = 1'b1;
    cpu_write(16'h801B, 8'h02); m_nt[3] = 1'b0;
    for (int i = 0; i < 4; i++) look_nt(i, "R5");
  endtask

  task automatic t_alias();  // R6
    cpu_write(16'hF018, 8'h00); m_nt[0]  = 1'b0;
    cpu_write(16'hC003, 8'h05); m_prg[2] = 4'h5;
    cpu_write(16'hA010, 8'h44); m_chr[0] = 7'h44;
    cpu_write(16'hFFFB, 8'h01); m_nt[3]  = 1'b1;
    look_all("R6");
  endtask

  task automatic t_low_half();  // R1
    cpu_write(16'h0000, 8'h09);
    cpu_write(16'h6011, 8'h33);
    cpu_write(16'h7FF9, 8'h01);
    look_all("R1");
  endtask

  task automatic t_one_reg();  // R9
    cpu_write(16'h8015, 8'h6E); m_chr[5] = 7'h6E;
    look_all("R9");
    cpu_write(16'hA000, 8'h0C); m_prg[1] = 4'hC;
    look_all("R9");
  endtask

  task automatic t_vram();  // R7
    ppu_addr = 14'h1FFF; #1; chk("R7", "cs at $1FFF", 32'(vram_cs), 32'd0);
    ppu_addr = 14'h2000; #1; chk("R7", "cs at $2000", 32'(vram_cs), 32'd1);
    ppu_addr = 14'h3EFF; #1; chk("R7", "cs at $3EFF", 32'(vram_cs), 32'd1);
    ppu_addr = 14'h3F00; #1; chk("R7", "cs at $3F00", 32'(vram_cs), 32'd0);
    ppu_addr = 14'h3C10; #1;
    chk("R7", "page at $3C10", 32'(vram_page), 32'(m_nt[3]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    look_all("R8");
    t_prg();
    t_fixed();
    t_chr();
    t_nt();
    t_alias();
    t_low_half();
    t_one_reg();
    t_vram();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule